// File: doc/BRIEF.md
# Write-Restricted Way Redirection Logic

This block makes the placement decision for one set of a last-level cache that rotates write protection across groups of ways. The ways of the set are split into equal, contiguous windows. At any time one window may be marked as write-protected. The block receives the tag lookup result for a request from the upper-level cache. It then names the way that serves or receives the request. A write must never land in the protected window, so a write that hits there is steered to another way of the same set, and the stale copy is dropped. Fills after a miss are also kept out of the protected window.

Every output is a pure function of the inputs in the same cycle. The block has no storage. There is no data stream here and so no valid/ready pair. `req_valid` is a plain qualifier: while it is low, every action flag is held low. The surrounding controller owns the tag and data arrays, the per-window write counters, the choice of which window is protected, and all traffic to the next level.

Top module: `wwr_redirect`

## Requirements
- R1: A valid read hit is served from `hit_way`, with `evict`, `inv_old` and `cnt_en` all low. This holds even when that way lies in the protected window.
- R2: A valid write hit to a way outside the protected window is written in place. `tgt_way` equals `hit_way`, `cnt_en` is high, and `cnt_win` is `hit_way / (NUM_WAYS/NUM_WIN)`.
- R3: A valid write hit inside the protected window goes to the lowest-numbered invalid way outside that window, with `evict` low.
- R4: When every way outside the protected window is valid, a redirected write or a fill goes to `victim_hint` if the hint lies outside the window, and `evict` is high.
- R5: When eviction is needed and `victim_hint` lies inside the protected window, the lowest-numbered way outside the window is used instead.
- R6: On a redirected write, `inv_old` is high and `inv_way` equals `hit_way`. In every other case `inv_old` is low.
- R7: On a redirected write, `cnt_en` is high and `cnt_win` is the window of `tgt_way`.
- R8: On a miss (read or write), `tgt_way` follows the placement rules of R3 to R5, `cnt_en` and `inv_old` are low, and `evict` is high only when no invalid way is allowed.
- R9: With `rwin_on` low, no way is protected. Write hits stay in place, and a miss picks the lowest invalid way of the whole set, or else the hint.
- R10: With `req_valid` low, `tgt_way`, `inv_way` and `cnt_win` are zero and every flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A lookup result is present this cycle |
| req_write | input | 1 | 1 = write-back from the upper level, 0 = read |
| req_hit | input | 1 | The tag lookup hit |
| hit_way | input | WAY_W | Way that hit (ignored on a miss) |
| way_valid | input | NUM_WAYS | Valid bit of each way in the set |
| rwin_idx | input | WIN_W | Index of the protected window |
| rwin_on | input | 1 | Write protection is active |
| victim_hint | input | WAY_W | Replacement policy's preferred victim |
| tgt_way | output | WAY_W | Way that serves or receives the request |
| evict | output | 1 | The line now in `tgt_way` must be evicted first |
| inv_old | output | 1 | Invalidate the copy in `inv_way` |
| inv_way | output | WAY_W | Way to invalidate |
| cnt_en | output | 1 | Increment a window write counter |
| cnt_win | output | WIN_W | Window whose counter is incremented |

## Verification
The bench sweeps every valid-bit pattern against every protected window, hint, request kind and hit way. This reaches the corner where a hit lands in the protected window and every allowed way is full. A design that ignored the window there would write into protected storage or evict the wrong line. Hints that point into the window are covered: logic that skipped the fallback would place a fill in a protected way. Full sets with protection off are covered too: logic that masked anyway would never use the protected ways. The counter window is checked separately from the target way. A design that credited the window of the old copy on a redirect would fail that check.

// File: rtl/wwr_pkg.sv
`timescale 1ns/1ps
package wwr_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE     = 2'd0,
    ACT_IN_PLACE = 2'd1,
    ACT_REDIRECT = 2'd2,
    ACT_FILL     = 2'd3
  } wwr_action_e;
endpackage

// File: rtl/wwr_win_mask.sv
`timescale 1ns/1ps
// Marks which ways may be written: all ways when protection is off,
// otherwise every way outside the protected window.
module wwr_win_mask #(
  parameter int NUM_WAYS = 8,
  parameter int NUM_WIN  = 4,
  localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int WPW     = NUM_WAYS / NUM_WIN
) (
  input  logic [WIN_W-1:0]    win_idx,
  input  logic                win_on,
  output logic [NUM_WAYS-1:0] allowed
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    assign allowed[g] = !win_on || (WIN_W'(g / WPW) != win_idx);
  end
endmodule

// File: rtl/wwr_low_pick.sv
`timescale 1ns/1ps
// Lowest-index set bit of a request vector.
module wwr_low_pick #(
  parameter int N  = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/wwr_redirect.sv
`timescale 1ns/1ps
module wwr_redirect
  import wwr_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_WIN  = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int WPW     = NUM_WAYS / NUM_WIN
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_hit,
  input  logic [WAY_W-1:0]    hit_way,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [WIN_W-1:0]    rwin_idx,
  input  logic                rwin_on,
  input  logic [WAY_W-1:0]    victim_hint,
  output logic [WAY_W-1:0]    tgt_way,
  output logic                evict,
  output logic                inv_old,
  output logic [WAY_W-1:0]    inv_way,
  output logic                cnt_en,
  output logic [WIN_W-1:0]    cnt_win
);

  function automatic logic [WIN_W-1:0] win_of(input logic [WAY_W-1:0] w);
    return WIN_W'(int'(w) / WPW);
  endfunction

  logic [NUM_WAYS-1:0] allowed;
  logic [NUM_WAYS-1:0] free_ok;
  logic                any_free;
  logic [WAY_W-1:0]    free_way;
  logic                any_allowed;
  logic [WAY_W-1:0]    low_allowed;
  logic [WAY_W-1:0]    victim_way;
  logic [WAY_W-1:0]    place_way;
  logic                place_evict;
  logic                hit_protected;
  wwr_action_e         action;

  wwr_win_mask #(.NUM_WAYS(NUM_WAYS), .NUM_WIN(NUM_WIN)) i_mask (
    .win_idx (rwin_idx),
    .win_on  (rwin_on),
    .allowed (allowed)
  );

  assign free_ok = allowed & ~way_valid;

  wwr_low_pick #(.N(NUM_WAYS)) i_pick_free (
    .req   (free_ok),
    .found (any_free),
    .idx   (free_way)
  );

  wwr_low_pick #(.N(NUM_WAYS)) i_pick_fallback (
    .req   (allowed),
    .found (any_allowed),
    .idx   (low_allowed)
  );

  // Victim steering: a hint inside the protected window falls back.
  assign victim_way  = allowed[victim_hint] ? victim_hint : low_allowed;
  assign place_way   = any_free ? free_way : victim_way;
  assign place_evict = !any_free;

  assign hit_protected = rwin_on && (win_of(hit_way) == rwin_idx);

  always_comb begin
    if (!req_valid)                     action = ACT_IDLE;
    else if (!req_hit)                  action = ACT_FILL;
    else if (req_write && hit_protected) action = ACT_REDIRECT;
    else                                action = ACT_IN_PLACE;
  end

  always_comb begin
    tgt_way = '0;
    evict   = 1'b0;
    inv_old = 1'b0;
    inv_way = '0;
    cnt_en  = 1'b0;
    cnt_win = '0;
    unique case (action)
      ACT_IN_PLACE: begin
        tgt_way = hit_way;
        cnt_en  = req_write;
        cnt_win = req_write ? win_of(hit_way) : '0;
      end
      ACT_REDIRECT: begin
        tgt_way = place_way;
        evict   = place_evict;
        inv_old = 1'b1;
        inv_way = hit_way;
        cnt_en  = 1'b1;
        cnt_win = win_of(place_way);
      end
      ACT_FILL: begin
        tgt_way = place_way;
        evict   = place_evict;
      end
      default: ;
    endcase
  end

  // Checks on the combined decision
  always_comb begin
    if (!$isunknown({req_valid, req_write, req_hit, hit_way, way_valid,
                     rwin_idx, rwin_on, victim_hint})) begin
      AST_ALLOWED_NONEMPTY: assert (any_allowed)
        else $error("no writable way in set"); // R5
      AST_READ_HIT_IN_PLACE: assert (!(req_valid && req_hit && !req_write) ||
                                     (tgt_way == hit_way && !evict && !cnt_en))
        else $error("read hit moved"); // R1
      AST_WRITE_AVOIDS_WINDOW: assert (!(req_valid && rwin_on && !(req_hit && !req_write)) ||
                                       win_of(tgt_way) != rwin_idx)
        else $error("write or fill into protected window"); // R3
      AST_EVICT_HITS_VALID: assert (!evict || way_valid[tgt_way])
        else $error("eviction of an invalid way"); // R4
      AST_INV_OLD_PROTECTED: assert (!inv_old ||
                                     (rwin_on && win_of(inv_way) == rwin_idx && inv_way != tgt_way))
        else $error("invalidation outside protected window"); // R6
      AST_COUNT_TARGET_WIN: assert (!cnt_en || cnt_win == win_of(tgt_way))
        else $error("counter window differs from target"); // R7
      AST_IDLE_QUIET: assert (req_valid || (!evict && !inv_old && !cnt_en && tgt_way == '0))
        else $error("activity while idle"); // R10
    end
  end

endmodule

// File: tb/test_wwr_redirect.sv
`timescale 1ns/1ps
module test_wwr_redirect;
  localparam int NW  = 8;
  localparam int NWN = 4;
  localparam int WPW = NW / NWN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid, req_write, req_hit, rwin_on;
  logic [2:0]    hit_way, victim_hint, tgt_way, inv_way;
  logic [NW-1:0] way_valid;
  logic [1:0]    rwin_idx, cnt_win;
  logic          evict, inv_old, cnt_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int cycles = 0;

  wwr_redirect #(.NUM_WAYS(NW), .NUM_WIN(NWN)) i_wwr_redirect (
    .req_valid(req_valid), .req_write(req_write), .req_hit(req_hit),
    .hit_way(hit_way), .way_valid(way_valid), .rwin_idx(rwin_idx),
    .rwin_on(rwin_on), .victim_hint(victim_hint), .tgt_way(tgt_way),
    .evict(evict), .inv_old(inv_old), .inv_way(inv_way),
    .cnt_en(cnt_en), .cnt_win(cnt_win)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Model computed from the requirements
  task automatic check_one(input string tag);
    int e_tgt, e_inv_way, e_cwin, first_free, low_ok, vic, place;
    bit e_evict, e_inv, e_cnt, prot, hp;
    bit ok_w [NW];
    #1;
    e_tgt = 0; e_evict = 0; e_inv = 0; e_inv_way = 0; e_cnt = 0; e_cwin = 0;
    first_free = -1; low_ok = -1;
    for (int w = 0; w < NW; w++) begin
      ok_w[w] = !rwin_on || ((w / WPW) != int'(rwin_idx));
      if (ok_w[w] && low_ok < 0) low_ok = w;
      if (ok_w[w] && !way_valid[w] && first_free < 0) first_free = w;
    end
    vic   = ok_w[victim_hint] ? int'(victim_hint) : low_ok;
    place = (first_free >= 0) ? first_free : vic;
    hp    = rwin_on && ((int'(hit_way) / WPW) == int'(rwin_idx));
    prot  = 0;
    if (req_valid) begin
      if (!req_hit) begin
        e_tgt = place; e_evict = (first_free < 0);
      end else if (req_write && hp) begin
        prot = 1;
        e_tgt = place; e_evict = (first_free < 0);
        e_inv = 1; e_inv_way = hit_way; e_cnt = 1; e_cwin = place / WPW;
      end else begin
        e_tgt = hit_way;
        if (req_write) begin e_cnt = 1; e_cwin = int'(hit_way) / WPW; end
      end
    end
    tests++;
    if (int'(tgt_way) != e_tgt || evict != e_evict || inv_old != e_inv ||
        int'(inv_way) != e_inv_way || cnt_en != e_cnt || int'(cnt_win) != e_cwin) begin
      fails++;
      $display("FAIL %s: v=%b on=%0d win=%0d w=%0d h=%0d hw=%0d hint=%0d actual tgt=%0d ev=%0d inv=%0d/%0d cnt=%0d/%0d expected tgt=%0d ev=%0d inv=%0d/%0d cnt=%0d/%0d",
               tag, way_valid, rwin_on, rwin_idx, req_write, req_hit, hit_way, victim_hint,
               tgt_way, evict, inv_old, inv_way, cnt_en, cnt_win,
               e_tgt, e_evict, e_inv, e_inv_way, e_cnt, e_cwin);
    end
    if (prot) begin end
  endtask

  function automatic string tag_for(input int fw, input bit hint_in);
    if (!req_valid) return "R10";
    if (!rwin_on) return "R9";
    if (!req_hit) return "R8";
    if (!req_write) return "R1";
    if (!(rwin_on && ((int'(hit_way) / WPW) == int'(rwin_idx)))) return "R2";
    if (fw) return "R3/R6/R7";
    if (hint_in) return "R5/R6/R7";
    return "R4/R6/R7";
  endfunction

  initial begin
    req_valid = 0; req_write = 0; req_hit = 0; hit_way = 0; way_valid = '0;
    rwin_idx = 0; rwin_on = 0; victim_hint = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle state, including with stimulus on other pins
    check_one("R10");
    req_write = 1; req_hit = 1; hit_way = 3'd1; way_valid = 8'hFF; rwin_on = 1;
    check_one("R10");
    req_valid = 1;
    for (int vv = 0; vv < 256; vv++) begin
      for (int on = 0; on < 2; on++) begin
        for (int rw = 0; rw < NWN; rw++) begin
          for (int hn = 0; hn < NW; hn++) begin
            for (int k = 0; k < 2 + 2 * NW; k++) begin
              int fw;
              bit hint_in;
              rwin_on = on[0]; rwin_idx = rw[1:0]; victim_hint = hn[2:0];
              if (k < 2) begin
                req_hit = 0; req_write = k[0]; hit_way = 0; way_valid = vv[NW-1:0];
              end else begin
                req_hit = 1; req_write = k[0]; hit_way = 3'((k - 2) / 2);
                way_valid = vv[NW-1:0] | (NW'(1) << hit_way);
              end
              fw = 0;
              for (int w = 0; w < NW; w++)
                if (!way_valid[w] && (!rwin_on || (w / WPW) != rw)) fw = 1;
              hint_in = rwin_on && ((hn / WPW) == rw);
              check_one(tag_for(fw, hint_in));
            end
          end
        end
      end
    end
    req_valid = 0;
    check_one("R10");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule